// File: doc/BRIEF.md
# In-Order Read Response Queue

This block sits on one requester port of a banked memory and puts read responses back into the order in which their reads were issued. Responses from different banks come back with different latencies, so a later read can finish before an earlier one. When the port issues a read, it asks the queue for a slot. The queue hands back the index of its current tail slot as a tag, and that tag travels with the read request. When the data comes back, it carries the same tag. The data is stored in that slot and the slot's presence bit is set.

The queue keeps a head pointer and a tail pointer like an ordinary FIFO. The slots between them can hold data that has arrived or reads that are still outstanding. The queue offers the head slot on its output only once that slot's presence bit is set. Popping the head clears the bit and moves the head on. A response that arrives early for a later slot therefore waits until every earlier slot has been released.

The number of reads in flight is limited to the queue depth. If the round-trip time through the banks is longer than the depth, the port has to stall on the full flag.

Top module: `rsp_reorder_queue`

## Requirements
- R1: While reset is held, and after it is released with no activity, `full` is 0, `out_valid` is 0 and `alloc_tag` is 0.
- R2: `alloc_gnt` is combinational in the same cycle as `alloc_req`. `alloc_tag` shows the slot the next grant will receive. Successive grants receive consecutive slot indices, counting modulo DEPTH.
- R3: `full` is 1 exactly when DEPTH slots are allocated and not yet popped. In that state `alloc_req` is refused, even in a cycle with a pop, and `alloc_tag` does not change.
- R4: A response accepted at a clock edge for the head slot makes `out_valid` 1 after that same edge. `out_data` then equals the response data and `out_tag` equals the head slot index.
- R5: A response for a slot other than the head is stored, but `out_valid` stays 0 until the head slot's own response arrives.
- R6: Entries leave in the order their slots were allocated, whatever order the responses arrive in, and each carries its own data.
- R7: A pop is `out_valid` and `out_ready` both 1 at a clock edge. A pop advances the head by one and frees one slot, so `full` falls after that edge. While `out_ready` is 0, `out_valid`, `out_tag` and `out_data` hold.
- R8: A grant, a response and a pop in the same cycle all take effect at that one clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released internally on the clock |
| alloc_req | input | 1 | Request a slot for a newly issued read |
| alloc_gnt | output | 1 | Slot granted this cycle |
| alloc_tag | output | TAG_W | Slot index given to the request, to travel with it |
| full | output | 1 | All DEPTH slots are allocated |
| rsp_valid | input | 1 | A read response is presented |
| rsp_tag | input | TAG_W | Slot index of the response |
| rsp_data | input | DATA_W | Response data |
| out_valid | output | 1 | The head slot holds data ready to leave |
| out_ready | input | 1 | The consumer accepts the head entry |
| out_tag | output | TAG_W | Slot index of the head entry |
| out_data | output | DATA_W | Data of the head entry |

## Verification
`alloc_gnt` and `alloc_tag` are due in the cycle of the request. `out_valid` and the head data are due one clock edge after the head's response. `full` moves one edge after the grant or pop that changes the slot count. Each bench step drives inputs on the falling edge and samples all outputs 1 ns later, before the next rising edge. As a result, combinational results are read in their own cycle, and registered results are read exactly one step after their cause. The scenarios are: in-order responses, fully reversed responses, shuffled responses with random back-pressure, a full queue, a held output, and a cycle that combines a grant, a response and a pop.

// File: rtl/rq_pkg.sv
package rq_pkg;
  parameter int RQ_DEPTH_DEF  = 16;
  parameter int RQ_DATA_W_DEF = 32;

  // Slot occupancy on the next cycle given grant and pop strobes.
  function automatic int unsigned rq_next_count(input int unsigned cur,
                                                input logic grant,
                                                input logic pop);
    int unsigned n;
    n = cur;
    if (grant) n = n + 1;
    if (pop)   n = n - 1;
    return n;
  endfunction
endpackage

// File: rtl/rq_rst_sync.sv
module rq_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic stage_q;
  logic out_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q <= 1'b0;
      out_q   <= 1'b0;
    end else begin
      stage_q <= 1'b1;
      out_q   <= stage_q;
    end
  end

  assign rst_sync_n = out_q;
endmodule

// File: rtl/rq_ptr_ctrl.sv
module rq_ptr_ctrl #(
  parameter int DEPTH = 16,
  localparam int TAG_W = $clog2(DEPTH),
  localparam int CNT_W = TAG_W + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             grant,
  input  logic             pop,
  output logic [TAG_W-1:0] head,
  output logic [TAG_W-1:0] tail,
  output logic             full
);
  import rq_pkg::*;

  logic [TAG_W-1:0] head_q, head_d;
  logic [TAG_W-1:0] tail_q, tail_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             head_en, tail_en, cnt_en;

  assign head_en = pop;
  assign tail_en = grant;
  assign cnt_en  = grant ^ pop;

  always_comb begin
    head_d = head_q + TAG_W'(1);
    tail_d = tail_q + TAG_W'(1);
    cnt_d  = CNT_W'(rq_next_count(int'(cnt_q), grant, pop));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      head_q <= '0;
      tail_q <= '0;
      cnt_q  <= '0;
    end else begin
      if (head_en) head_q <= head_d;
      if (tail_en) tail_q <= tail_d;
      if (cnt_en)  cnt_q  <= cnt_d;
    end
  end

  assign head = head_q;
  assign tail = tail_q;
  assign full = (cnt_q == CNT_W'(DEPTH));

  // R3: outstanding slots never exceed the depth
  assert_no_overflow_R3: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CNT_W'(DEPTH));

  // R7: a pop never happens with nothing allocated
  assert_no_underflow_R7: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> (cnt_q != '0));

  // R2: a grant moves the tail by exactly one slot
  assert_tail_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    grant |=> (tail_q == $past(tail_q) + TAG_W'(1)));
endmodule

// File: rtl/rq_presence.sv
module rq_presence #(
  parameter int DEPTH = 16,
  localparam int TAG_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             set_en,
  input  logic [TAG_W-1:0] set_idx,
  input  logic             clr_en,
  input  logic [TAG_W-1:0] clr_idx,
  input  logic [TAG_W-1:0] head_idx,
  output logic             head_present
);
  logic [DEPTH-1:0] bits_q;

  for (genvar s = 0; s < DEPTH; s++) begin : g_bit
    logic hit_set, hit_clr, bit_en, bit_d;
    always_comb begin
      hit_set = set_en && (set_idx == TAG_W'(s));
      hit_clr = clr_en && (clr_idx == TAG_W'(s));
      bit_en  = hit_set || hit_clr;
      bit_d   = hit_set;
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      bits_q[s] <= 1'b0;
      else if (bit_en) bits_q[s] <= bit_d;
    end
  end

  assign head_present = bits_q[head_idx];

  // R7: the slot released by a pop is empty afterwards
  assert_pop_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_en && !(set_en && set_idx == clr_idx)) |=> !bits_q[$past(clr_idx)]);

  // R5: a stored response leaves its slot marked present
  assert_store_marks_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (set_en && !(clr_en && clr_idx == set_idx)) |=> bits_q[$past(set_idx)]);
endmodule

// File: rtl/rq_slot_store.sv
module rq_slot_store #(
  parameter int DEPTH  = 16,
  parameter int DATA_W = 32,
  localparam int TAG_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              wr_en,
  input  logic [TAG_W-1:0]  wr_idx,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [TAG_W-1:0]  rd_idx,
  output logic [DATA_W-1:0] rd_data
);
  logic [DATA_W-1:0] slot_q [DEPTH];

  for (genvar s = 0; s < DEPTH; s++) begin : g_slot
    logic slot_en;
    assign slot_en = wr_en && (wr_idx == TAG_W'(s));
    always_ff @(posedge clk) begin
      if (slot_en) slot_q[s] <= wr_data;
    end
  end

  assign rd_data = slot_q[rd_idx];
endmodule

// File: rtl/rsp_reorder_queue.sv
module rsp_reorder_queue #(
  parameter int DEPTH  = rq_pkg::RQ_DEPTH_DEF,
  parameter int DATA_W = rq_pkg::RQ_DATA_W_DEF,
  localparam int TAG_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              alloc_req,
  output logic              alloc_gnt,
  output logic [TAG_W-1:0]  alloc_tag,
  output logic              full,
  input  logic              rsp_valid,
  input  logic [TAG_W-1:0]  rsp_tag,
  input  logic [DATA_W-1:0] rsp_data,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [TAG_W-1:0]  out_tag,
  output logic [DATA_W-1:0] out_data
);
  logic             rst_int_n;
  logic [TAG_W-1:0] head, tail;
  logic             full_int, head_present, pop;

  rq_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_int_n)
  );

  assign alloc_gnt = alloc_req && !full_int;
  assign pop       = head_present && out_ready;

  rq_ptr_ctrl #(.DEPTH(DEPTH)) u_ptr (
    .clk   (clk),
    .rst_n (rst_int_n),
    .grant (alloc_gnt),
    .pop   (pop),
    .head  (head),
    .tail  (tail),
    .full  (full_int)
  );

  rq_presence #(.DEPTH(DEPTH)) u_pres (
    .clk          (clk),
    .rst_n        (rst_int_n),
    .set_en       (rsp_valid),
    .set_idx      (rsp_tag),
    .clr_en       (pop),
    .clr_idx      (head),
    .head_idx     (head),
    .head_present (head_present)
  );

  rq_slot_store #(.DEPTH(DEPTH), .DATA_W(DATA_W)) u_store (
    .clk     (clk),
    .wr_en   (rsp_valid),
    .wr_idx  (rsp_tag),
    .wr_data (rsp_data),
    .rd_idx  (head),
    .rd_data (out_data)
  );

  assign alloc_tag = tail;
  assign full      = full_int;
  assign out_valid = head_present;
  assign out_tag   = head;

  // R4: a response to the waiting head is offered after the same edge
  assert_head_release_R4: assert property (@(posedge clk) disable iff (!rst_int_n)
    (rsp_valid && rsp_tag == head && !pop) |=> (out_valid && out_data == $past(rsp_data)));

  // R7: an offered entry is held while the consumer stalls
  assert_hold_R7: assert property (@(posedge clk) disable iff (!rst_int_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_tag)));

  // R3: a full queue keeps its tail
  assert_full_tail_R3: assert property (@(posedge clk) disable iff (!rst_int_n)
    full |=> (alloc_tag == $past(alloc_tag)));
endmodule

// File: tb/tb_rsp_reorder_queue.sv
`timescale 1ns/1ps
module tb_rsp_reorder_queue;
  localparam int DEPTH  = 16;
  localparam int DATA_W = 32;
  localparam int TW     = $clog2(DEPTH);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic alloc_req = 1'b0, rsp_valid = 1'b0, out_ready = 1'b0;
  logic [TW-1:0] rsp_tag = '0;
  logic [DATA_W-1:0] rsp_data = '0;
  logic alloc_gnt, full, out_valid;
  logic [TW-1:0] alloc_tag, out_tag;
  logic [DATA_W-1:0] out_data;

  int total = 0, bad = 0;
  logic [TW-1:0] exp_head = '0, exp_tail = '0;
  logic [DATA_W-1:0] exp_data [DEPTH];
  logic [15:0] lfsr = 16'hACE1;

  // sampled outputs of the current step
  logic s_gnt, s_full, s_ov;
  logic [TW-1:0] s_tag, s_otag;
  logic [DATA_W-1:0] s_odata;

  always #5 clk = ~clk;

  rsp_reorder_queue #(.DEPTH(DEPTH), .DATA_W(DATA_W)) dut (
    .clk(clk), .rst_n(rst_n), .alloc_req(alloc_req), .alloc_gnt(alloc_gnt),
    .alloc_tag(alloc_tag), .full(full), .rsp_valid(rsp_valid), .rsp_tag(rsp_tag),
    .rsp_data(rsp_data), .out_valid(out_valid), .out_ready(out_ready),
    .out_tag(out_tag), .out_data(out_data));

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] nx(input logic [15:0] v);
    return {v[14:0], v[15] ^ v[13] ^ v[12] ^ v[10]};
  endfunction

  // one clock step: drive at falling edge, sample 1 ns later, then rising edge
  task automatic step(input logic a, input logic rv, input logic [TW-1:0] rt,
                      input logic [DATA_W-1:0] rd, input logic rdy);
    @(negedge clk);
    alloc_req = a; rsp_valid = rv; rsp_tag = rt; rsp_data = rd; out_ready = rdy;
    #1;
    s_gnt = alloc_gnt; s_full = full; s_ov = out_valid;
    s_tag = alloc_tag; s_otag = out_tag; s_odata = out_data;
    @(posedge clk);
  endtask

  task automatic alloc_n(input int n);
    for (int i = 0; i < n; i++) begin
      step(1'b1, 1'b0, '0, '0, 1'b0);
      chk("R2 grant", 64'(s_gnt), 64'd1);
      chk("R2 tag", 64'(s_tag), 64'(exp_tail));
      exp_tail = exp_tail + TW'(1);
    end
  endtask

  task automatic respond(input logic [TW-1:0] t, input logic rdy);
    exp_data[t] = 32'hD000_0000 ^ {lfsr, 16'(t)};
    lfsr = nx(lfsr);
    step(1'b0, 1'b1, t, exp_data[t], rdy);
  endtask

  task automatic drain(input int n, input string req);
    for (int i = 0; i < n; i++) begin
      step(1'b0, 1'b0, '0, '0, 1'b1);
      chk({req, " valid"}, 64'(s_ov), 64'd1);
      chk({req, " order"}, 64'(s_otag), 64'(exp_head));
      chk({req, " data"}, 64'(s_odata), 64'(exp_data[exp_head]));
      exp_head = exp_head + TW'(1);
    end
  endtask

  task automatic t_reset;
    step(1'b0, 1'b0, '0, '0, 1'b0);
    chk("R1 full", 64'(s_full), 64'd0);
    chk("R1 out_valid", 64'(s_ov), 64'd0);
    chk("R1 alloc_tag", 64'(s_tag), 64'd0);
  endtask

  task automatic t_in_order;
    alloc_n(4);
    respond(exp_head, 1'b0);
    step(1'b0, 1'b0, '0, '0, 1'b0);
    chk("R4 valid after edge", 64'(s_ov), 64'd1);
    chk("R4 data", 64'(s_odata), 64'(exp_data[exp_head]));
    for (int i = 1; i < 4; i++) respond(exp_head + TW'(i), 1'b0);
    drain(4, "R6 in-order");
  endtask

  task automatic t_reverse;
    alloc_n(4);
    for (int i = 3; i >= 1; i--) begin
      respond(exp_head + TW'(i), 1'b0);
      step(1'b0, 1'b0, '0, '0, 1'b0);
      chk("R5 held back", 64'(s_ov), 64'd0);
    end
    respond(exp_head, 1'b0);
    drain(4, "R6 reversed");
  endtask

  task automatic t_random;
    logic [TW-1:0] ord [DEPTH];
    int k = 0, got = 0, guard = 0;
    for (int i = 0; i < DEPTH; i++) ord[i] = exp_head + TW'(i);
    for (int i = DEPTH - 1; i > 0; i--) begin
      int j;
      lfsr = nx(lfsr);
      j = int'(lfsr) % (i + 1);
      begin logic [TW-1:0] t; t = ord[i]; ord[i] = ord[j]; ord[j] = t; end
    end
    alloc_n(DEPTH);
    while (got < DEPTH && guard < 400) begin
      logic rdy, rv;
      logic [TW-1:0] t;
      guard++;
      lfsr = nx(lfsr);
      rdy = lfsr[3];
      rv = (k < DEPTH);
      t = rv ? ord[k] : '0;
      if (rv) begin exp_data[t] = {lfsr, 16'(guard)}; k++; end
      step(1'b0, rv, t, rv ? exp_data[t] : '0, rdy);
      if (s_ov && rdy) begin
        chk("R6 random order", 64'(s_otag), 64'(exp_head));
        chk("R6 random data", 64'(s_odata), 64'(exp_data[exp_head]));
        exp_head = exp_head + TW'(1);
        got++;
      end
    end
    chk("R6 random all out", 64'(got), 64'(DEPTH));
  endtask

  task automatic t_full;
    alloc_n(DEPTH);
    step(1'b1, 1'b0, '0, '0, 1'b0);
    chk("R3 full", 64'(s_full), 64'd1);
    chk("R3 refused", 64'(s_gnt), 64'd0);
    chk("R3 tag kept", 64'(s_tag), 64'(exp_tail));
    respond(exp_head, 1'b0);
    step(1'b1, 1'b0, '0, '0, 1'b1);
    chk("R3 refused during pop", 64'(s_gnt), 64'd0);
    exp_head = exp_head + TW'(1);
    step(1'b0, 1'b0, '0, '0, 1'b0);
    chk("R7 full drops after pop", 64'(s_full), 64'd0);
    for (int i = 0; i < DEPTH - 1; i++) respond(exp_head + TW'(i), 1'b0);
    drain(DEPTH - 1, "R6 after full");
  endtask

  task automatic t_hold;
    alloc_n(2);
    respond(exp_head, 1'b0);
    for (int i = 0; i < 3; i++) begin
      step(1'b0, 1'b0, '0, '0, 1'b0);
      chk("R7 hold valid", 64'(s_ov), 64'd1);
      chk("R7 hold data", 64'(s_odata), 64'(exp_data[exp_head]));
    end
    respond(exp_head + TW'(1), 1'b0);
    drain(2, "R7 after hold");
  endtask

  task automatic t_concurrent;
    logic [TW-1:0] t1;
    alloc_n(2);
    t1 = exp_head + TW'(1);
    respond(exp_head, 1'b0);
    exp_data[t1] = 32'h5A5A_0000 | 32'(t1);
    step(1'b1, 1'b1, t1, exp_data[t1], 1'b1);
    chk("R8 grant", 64'(s_gnt), 64'd1);
    chk("R8 popped head", 64'(s_otag), 64'(exp_head));
    exp_head = exp_head + TW'(1);
    exp_tail = exp_tail + TW'(1);
    step(1'b0, 1'b0, '0, '0, 1'b0);
    chk("R8 response took effect", 64'(s_ov), 64'd1);
    chk("R8 next head", 64'(s_otag), 64'(t1));
    chk("R8 tail moved", 64'(s_tag), 64'(exp_tail));
    respond(exp_head + TW'(1), 1'b0);
    drain(2, "R8 drain");
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #1;
    chk("R1 full in reset", 64'(full), 64'd0);
    chk("R1 valid in reset", 64'(out_valid), 64'd0);
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    repeat (4) @(posedge clk);
    t_reset();
    t_in_order();
    t_reverse();
    t_random();
    t_full();
    t_hold();
    t_concurrent();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule